// File: doc/BRIEF.md
# Garbage-Stack Reversible Operation Unit

This block lets a small register file run operations that would normally destroy information, a bitwise AND of two registers and a register clear, while keeping the whole computation reversible. Before a destination register is overwritten, its old contents are exchanged into a temporary register. The result is then computed into the emptied destination, and the temporary is exchanged onto a private stack. No instruction can read or address that stack. Every transfer is an exchange that leaves its source at zero, so no value is ever copied or dropped.

Running the same operations with the direction input set to reverse, in the opposite order, unwinds the computation. Each reverse step pops the newest stack entry into the temporary and uncomputes the destination by clearing it, checking first that it held the value the forward step produced. It then exchanges the temporary back into the destination and frees the stack slot. An immediate XOR, which is reversible by nature, goes straight to the register file and leaves the stack alone. A read port exposes any register.

The controller has seven states. In ST_IDLE it accepts a start strobe. A single-cycle operation (XOR immediate, no-op, or a refused push or pop) completes there. A forward AND or CLR takes the path ST_IDLE -> ST_F_MOVE -> ST_F_COMP -> ST_F_PUSH -> ST_IDLE. A reverse AND or CLR takes the path ST_IDLE -> ST_R_POP -> ST_R_UNCOMP -> ST_R_MOVE -> ST_IDLE. Every transition other than the exit from ST_IDLE is unconditional.

Top module: `gstk_unit`

## Requirements
- R1: After reset all registers read zero, busy and done are low, and the stack is empty.
- R2: With op = 2'b00 (XOR immediate), register ra becomes ra XOR imm in either direction. done pulses on the clock edge after the one that samples start, and the stack is unchanged.
- R3: A forward AND or CLR issued while the stack holds 16 entries raises overflow together with a one-cycle done on the next edge. The registers and the stack are left unchanged.
- R4: A forward op = 2'b01 (AND) sets ra to (old ra) AND rb and pushes old ra. If ra equals rb the result is zero, because the source has already been moved out. done pulses after the third edge following the start edge.
- R5: A forward op = 2'b10 (CLR) sets ra to zero and pushes old ra, with the same timing as R4.
- R6: Issuing the earlier operations with dir = 1 in reverse order restores every register exactly, last in first out, and empties the stack.
- R7: A reverse AND or CLR with an empty stack raises underflow together with a one-cycle done on the next edge, and changes nothing.
- R8: A reverse step whose destination does not equal the expected forward result (popped AND rb for AND, zero for CLR) pulses mismatch together with done. The destination still ends holding the popped value.
- R9: The temporary register is zero whenever the controller is idle, and operations change no register other than ra.
- R10: op = 2'b11 is a no-op. done pulses on the next edge and nothing changes.
- R11: A start strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in ST_IDLE only) |
| dir | input | 1 | 0 forward, 1 reverse (unwind) |
| op | input | 2 | 00 XOR immediate, 01 AND, 10 CLR, 11 no-op |
| ra | input | 2 | Destination register index |
| rb | input | 2 | Source register index for AND |
| imm | input | 8 | Immediate operand for XOR |
| rd_sel | input | 2 | Register read-out index |
| rd_data | output | 8 | Contents of register rd_sel |
| busy | output | 1 | High while a multi-step operation runs |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Forward push refused: stack full |
| underflow | output | 1 | Reverse pop refused: stack empty |
| mismatch | output | 1 | Reverse uncompute found an unexpected value |

## Verification
The embedded properties rely on the controller never asking the stack to push while full or to pop while empty. They also rely on start being acted on only in ST_IDLE, so the temporary is always empty between operations. The stimulus drives start for exactly one cycle at a time and waits for done before issuing more. The one exception is the deliberate mid-operation strobe that tests R11. The sweep fills the stack to exactly its depth, probes overflow and underflow only at those boundaries, and unwinds by replaying the logged operations backwards. Mismatch is provoked only through deliberate XOR edits of a saved destination.

// File: rtl/gstk_pkg.sv
package gstk_pkg;

    typedef enum logic [1:0] {
        OP_XORI = 2'b00,
        OP_AND  = 2'b01,
        OP_CLR  = 2'b10,
        OP_NOP  = 2'b11
    } gstk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_F_MOVE,
        ST_F_COMP,
        ST_F_PUSH,
        ST_R_POP,
        ST_R_UNCOMP,
        ST_R_MOVE
    } gstk_state_e;

endpackage

// File: rtl/gstk_regfile.sv
module gstk_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b,
    input  logic [AW-1:0] raddr_c,
    output logic [DW-1:0] rdata_c
);

    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && waddr == AW'(i)) begin
                regs[i] <= wdata;
            end
        end

        // only the addressed register may change (R9)
        assert_only_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == AW'(i)) |=> $stable(regs[i]));
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];

endmodule

// File: rtl/gstk_stack.sv
module gstk_stack #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] top,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_m1;

    assign sp_m1 = sp - PW'(1);
    assign full  = (sp == PW'(DEPTH));
    assign empty = (sp == '0);
    assign top   = empty ? '0 : mem[sp_m1[IW-1:0]];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (push && sp == PW'(i)) begin
                mem[i] <= wdata;
            end else if (pop && sp_m1 == PW'(i)) begin
                mem[i] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + PW'(1);
        end else if (pop && !empty) begin
            sp <= sp_m1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_push_pop_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (sp == $past(sp) - PW'(1)));

endmodule

// File: rtl/gstk_ctrl.sv
module gstk_ctrl
    import gstk_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir,
    input  logic [1:0]    op,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic [DW-1:0] imm,
    output logic [AW-1:0] rd_a_addr,
    output logic [AW-1:0] rd_b_addr,
    input  logic [DW-1:0] a_val,
    input  logic [DW-1:0] b_val,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata,
    input  logic          st_full,
    input  logic          st_empty,
    input  logic [DW-1:0] st_top,
    output logic          st_push,
    output logic          st_pop,
    output logic [DW-1:0] st_wdata,
    output logic          busy,
    output logic          done,
    output logic          overflow,
    output logic          underflow,
    output logic          mismatch
);

    gstk_state_e   state_q, state_d;
    gstk_op_e      op_q;
    logic [AW-1:0] ra_q, rb_q;
    logic [DW-1:0] temp;
    logic [DW-1:0] exp_a;
    logic          mism_q;
    logic          is_push_op;

    assign is_push_op = (op == OP_AND) || (op == OP_CLR);
    assign rd_a_addr  = (state_q == ST_IDLE) ? ra : ra_q;
    assign rd_b_addr  = (state_q == ST_IDLE) ? rb : rb_q;
    assign rf_waddr   = rd_a_addr;
    assign st_wdata   = temp;
    assign busy       = (state_q != ST_IDLE);
    assign exp_a      = (op_q == OP_AND) ? (temp & b_val) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and step strobes
    always_comb begin
        state_d  = state_q;
        rf_we    = 1'b0;
        rf_wdata = '0;
        st_push  = 1'b0;
        st_pop   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op == OP_XORI) begin
                        rf_we    = 1'b1;
                        rf_wdata = a_val ^ imm;
                    end else if (is_push_op) begin
                        if (!dir && !st_full)      state_d = ST_F_MOVE;
                        else if (dir && !st_empty) state_d = ST_R_POP;
                    end
                end
            end
            ST_F_MOVE: begin
                rf_we   = 1'b1;
                state_d = ST_F_COMP;
            end
            ST_F_COMP: begin
                if (op_q == OP_AND) begin
                    rf_we    = 1'b1;
                    rf_wdata = temp & b_val;
                end
                state_d = ST_F_PUSH;
            end
            ST_F_PUSH: begin
                st_push = 1'b1;
                state_d = ST_IDLE;
            end
            ST_R_POP: begin
                st_pop  = 1'b1;
                state_d = ST_R_UNCOMP;
            end
            ST_R_UNCOMP: begin
                rf_we   = 1'b1;
                state_d = ST_R_MOVE;
            end
            ST_R_MOVE: begin
                rf_we    = 1'b1;
                rf_wdata = temp;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs, temporary and latched operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_NOP;
            ra_q      <= '0;
            rb_q      <= '0;
            temp      <= '0;
            mism_q    <= 1'b0;
            done      <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            mismatch  <= 1'b0;
        end else begin
            done      <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            mismatch  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q <= gstk_op_e'(op);
                        ra_q <= ra;
                        rb_q <= rb;
                        if (!is_push_op) begin
                            done <= 1'b1;
                        end else if (!dir && st_full) begin
                            overflow <= 1'b1;
                            done     <= 1'b1;
                        end else if (dir && st_empty) begin
                            underflow <= 1'b1;
                            done      <= 1'b1;
                        end
                    end
                end
                ST_F_MOVE:   temp <= a_val;
                ST_F_COMP:   ;
                ST_F_PUSH: begin
                    temp <= '0;
                    done <= 1'b1;
                end
                ST_R_POP:    temp <= st_top;
                ST_R_UNCOMP: mism_q <= (a_val != exp_a);
                ST_R_MOVE: begin
                    temp     <= '0;
                    done     <= 1'b1;
                    mismatch <= mism_q;
                end
                default: ;
            endcase
        end
    end

    assert_temp_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (temp == '0));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_overflow_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && st_full));

    assert_underflow_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (done && st_empty));

    assert_mismatch_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> done);

    assert_busy_holds_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_d != ST_IDLE) |=> $stable(ra_q));

endmodule

// File: rtl/gstk_unit.sv
module gstk_unit #(
    parameter int DW    = 8,
    parameter int NREG  = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir,
    input  logic [1:0]    op,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic [DW-1:0] imm,
    input  logic [AW-1:0] rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          overflow,
    output logic          underflow,
    output logic          mismatch
);

    logic [AW-1:0] rd_a_addr, rd_b_addr, rf_waddr;
    logic [DW-1:0] a_val, b_val, rf_wdata, st_top, st_wdata;
    logic          rf_we, st_full, st_empty, st_push, st_pop;

    gstk_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir       (dir),
        .op        (op),
        .ra        (ra),
        .rb        (rb),
        .imm       (imm),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .a_val     (a_val),
        .b_val     (b_val),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .st_full   (st_full),
        .st_empty  (st_empty),
        .st_top    (st_top),
        .st_push   (st_push),
        .st_pop    (st_pop),
        .st_wdata  (st_wdata),
        .busy      (busy),
        .done      (done),
        .overflow  (overflow),
        .underflow (underflow),
        .mismatch  (mismatch)
    );

    gstk_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rd_a_addr),
        .rdata_a (a_val),
        .raddr_b (rd_b_addr),
        .rdata_b (b_val),
        .raddr_c (rd_sel),
        .rdata_c (rd_data)
    );

    gstk_stack #(.DW(DW), .DEPTH(DEPTH)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (st_push),
        .pop   (st_pop),
        .wdata (st_wdata),
        .top   (st_top),
        .full  (st_full),
        .empty (st_empty)
    );

endmodule

// File: tb/gstk_unit_test.sv
`timescale 1ns/1ps
module gstk_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir = 1'b0;
    logic [1:0] op = 2'b11;
    logic [1:0] ra = '0, rb = '0, rd_sel = '0;
    logic [7:0] imm = '0;
    logic [7:0] rd_data;
    logic       busy, done, overflow, underflow, mismatch;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_reg [4];
    logic [7:0] m_stk [16];
    int         m_sp = 0;

    logic [1:0] log_op [32];
    logic [1:0] log_a  [32];
    logic [1:0] log_b  [32];
    logic [7:0] log_im [32];
    logic [7:0] snap   [4];

    always #2 clk = ~clk;

    gstk_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .op(op),
        .ra(ra), .rb(rb), .imm(imm), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .done(done), .overflow(overflow),
        .underflow(underflow), .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #0.5;
            check(rd_data == m_reg[i], req, int'(rd_data), int'(m_reg[i]));
        end
    endtask

    task automatic do_op(input logic d, input logic [1:0] o, input logic [1:0] a,
                         input logic [1:0] b, input logic [7:0] im, input string req);
        int         ecyc, n;
        bit         eovf, eunf, emis, got;
        logic       govf, gunf, gmis;
        logic [7:0] t, bval;
        ecyc = 1; eovf = 0; eunf = 0; emis = 0;
        if (o == 2'b00) begin
            m_reg[a] = m_reg[a] ^ im;
        end else if (o != 2'b11) begin
            if (!d) begin
                if (m_sp == 16) eovf = 1;
                else begin
                    ecyc = 4;
                    t = m_reg[a];
                    m_stk[m_sp] = t;
                    m_sp++;
                    bval = (a == b) ? 8'h00 : m_reg[b];
                    m_reg[a] = (o == 2'b01) ? (t & bval) : 8'h00;
                end
            end else begin
                if (m_sp == 0) eunf = 1;
                else begin
                    ecyc = 4;
                    m_sp--;
                    t = m_stk[m_sp];
                    bval = m_reg[b];
                    emis = (m_reg[a] != ((o == 2'b01) ? (t & bval) : 8'h00));
                    m_reg[a] = t;
                end
            end
        end
        @(negedge clk);
        dir = d; op = o; ra = a; rb = b; imm = im; start = 1'b1;
        n = 0; got = 0; govf = 0; gunf = 0; gmis = 0;
        while (!got && n < 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                got = 1; govf = overflow; gunf = underflow; gmis = mismatch;
            end
        end
        check(n == ecyc, {req, " done latency"}, n, ecyc);
        check(govf == eovf, {req, " overflow (R3)"}, int'(govf), int'(eovf));
        check(gunf == eunf, {req, " underflow (R7)"}, int'(gunf), int'(eunf));
        check(gmis == emis, {req, " mismatch (R8)"}, int'(gmis), int'(emis));
        check_regs({req, " registers"});
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check_regs("R1 registers after reset");
        do_op(1'b1, 2'b01, 2'd0, 2'd1, 8'h00, "R1 R7 pop on empty stack");

        // R2: preload every register with XOR immediate
        for (int i = 0; i < 4; i++)
            do_op(1'b0, 2'b00, 2'(i), 2'(i), 8'((i * 8'h47) + 8'h1D), "R2 xor preload");
        for (int i = 0; i < 4; i++) snap[i] = m_reg[i];

        // R4: all 16 (ra, rb) pairs, refreshing ra before each AND
        k = 0;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                log_op[k] = 2'b00; log_a[k] = 2'(a); log_b[k] = 2'(b);
                log_im[k] = 8'((a * 37) + (b * 11) + 8'h5A);
                do_op(1'b0, 2'b00, log_a[k], log_b[k], log_im[k], "R2 xor refresh");
                k++;
                log_op[k] = 2'b01; log_a[k] = 2'(a); log_b[k] = 2'(b); log_im[k] = 8'h00;
                do_op(1'b0, 2'b01, log_a[k], log_b[k], 8'h00, "R4 forward and");
                k++;
            end
        end

        // R3: stack now holds 16 entries
        do_op(1'b0, 2'b10, 2'd2, 2'd0, 8'h00, "R3 clr on full stack");
        do_op(1'b0, 2'b01, 2'd1, 2'd3, 8'h00, "R3 and on full stack");

        // R6: unwind in reverse order
        for (int j = 31; j >= 0; j--)
            do_op(1'b1, log_op[j], log_a[j], log_b[j], log_im[j], "R6 unwind");
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #0.5;
            check(rd_data == snap[i], "R6 restored snapshot", int'(rd_data), int'(snap[i]));
        end
        do_op(1'b1, 2'b10, 2'd0, 2'd0, 8'h00, "R7 pop after full unwind");

        // R5: clear and its inverse
        do_op(1'b0, 2'b10, 2'd2, 2'd1, 8'h00, "R5 forward clr");
        do_op(1'b0, 2'b10, 2'd3, 2'd0, 8'h00, "R5 forward clr second");
        do_op(1'b1, 2'b10, 2'd3, 2'd0, 8'h00, "R5 reverse clr");
        do_op(1'b1, 2'b10, 2'd2, 2'd1, 8'h00, "R5 reverse clr second");

        // R8: tamper with a saved destination before unwinding
        do_op(1'b0, 2'b01, 2'd1, 2'd2, 8'h00, "R8 setup and");
        do_op(1'b0, 2'b00, 2'd1, 2'd1, 8'h01, "R8 tamper xor");
        do_op(1'b1, 2'b01, 2'd1, 2'd2, 8'h00, "R8 reverse and mismatch");
        do_op(1'b0, 2'b10, 2'd0, 2'd0, 8'h00, "R8 setup clr");
        do_op(1'b0, 2'b00, 2'd0, 2'd0, 8'h80, "R8 tamper xor clr");
        do_op(1'b1, 2'b10, 2'd0, 2'd0, 8'h00, "R8 reverse clr mismatch");

        // R10: no-op in both directions
        do_op(1'b0, 2'b11, 2'd1, 2'd2, 8'hFF, "R10 nop forward");
        do_op(1'b1, 2'b11, 2'd3, 2'd0, 8'hFF, "R10 nop reverse");

        // R11: strobe while busy is ignored
        m_stk[m_sp] = m_reg[0];
        m_sp++;
        m_reg[0] = 8'h00;
        @(negedge clk);
        dir = 1'b0; op = 2'b10; ra = 2'd0; rb = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 2'b00; ra = 2'd3; imm = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11 still busy", int'(busy), 1);
        k = 0;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
        end
        check(done == 1'b1, "R11 done after ignored strobe", int'(done), 1);
        @(negedge clk);
        check_regs("R11 xor during busy ignored");
        do_op(1'b1, 2'b10, 2'd0, 2'd0, 8'h00, "R11 R6 unwind after busy test");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule